// File: doc/BRIEF.md
# Device Power State Controller

This block holds the two-bit power state of a host controller function and applies that state to the rest of the function. Software reads and writes the state through a small register port. Only two encodings can be stored: full power (00b) and lowest power (11b). A write of any other code completes normally and leaves the stored state as it was.

While the function is in lowest power, the block ends every memory-mapped access with an abort response. It also holds the interrupt output low and records wake events in a sticky status bit. That status bit drives the power-management-event output. When software moves the function from lowest power back to full power, the block emits a one-cycle internal reset pulse that clears the rest of the function.

A function-level wrapper connects the register port, the memory-mapped request port, the raw interrupt, and the wake input to this block. It then uses the gated outputs in place of the raw ones.

Top module: `devpwr_ctrl`

## Requirements
- R1: After the external reset, the stored state is 00b, the event output is 0, the reset pulse is 0, and the state register reads back 0.
- R2: The state register sits at address STATE_ADDR with the state in bits [1:0]. A write of 00b or 11b is stored and reads back on the next cycle.
- R3: A write of 01b or 10b to the state register leaves the stored state unchanged and produces no reset pulse.
- R4: A write of 00b while the state is 11b raises the reset pulse for exactly one cycle, in the cycle after the write. A write of 00b in state 00b, or of 11b in state 11b, produces no pulse.
- R5: Each memory-mapped request gets a done response one cycle later. The abort flag is set with it when the state is 11b and clear when the state is 00b. A request in the same cycle as a state write is judged on the state before that write.
- R6: The interrupt output follows the raw interrupt in state 00b and stays 0 in state 11b.
- R7: A wake event in state 11b sets a sticky status bit, read at address STATUS_ADDR bit 0. This bit drives the event output from the next cycle onward. A wake event in state 00b sets nothing.
- R8: Writing 1 to STATUS_ADDR bit 0 clears the status bit and writing 0 leaves it. A wake event in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low external reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register address for read and write |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data for regAddr |
| mmioReq | input | 1 | Memory-mapped access request |
| mmioDone | output | 1 | Response for the request of the previous cycle |
| mmioAbort | output | 1 | Response is an abort |
| irqRaw | input | 1 | Interrupt from the function |
| irqOut | output | 1 | Gated interrupt |
| wakeEvt | input | 1 | Wake event from the function |
| pmeOut | output | 1 | Power-management-event level |
| fnRstPulse | output | 1 | One-cycle internal reset for the function |

## Verification
The bench builds the block with DATA_W=16, REG_AW=3, STATE_ADDR=2 and STATUS_ADDR=5, not the defaults. This places the two registers at non-adjacent, non-zero offsets. A decoder that ignores an address bit or confuses the two registers then shows up at the read port. The narrower data width keeps the upper write bits in play. The bench checks that they have no effect on the state.

// File: rtl/devpwr_pkg.sv
package devpwr_pkg;
  localparam logic [1:0] PS_FULL = 2'b00;
  localparam logic [1:0] PS_LOW  = 2'b11;

  typedef struct packed {
    logic       stateLoad;
    logic [1:0] stateVal;
    logic       rstFire;
    logic       pmeSet;
    logic       pmeClr;
  } ctrlStrobe_t;
endpackage

// File: rtl/devpwr_ctrl_path.sv
module devpwr_ctrl_path
  import devpwr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int REG_AW      = 4,
  parameter int STATE_ADDR  = 0,
  parameter int STATUS_ADDR = 1
) (
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [1:0]        wrLow,
  input  logic              wakeEvt,
  input  logic [1:0]        curState,
  output ctrlStrobe_t       strobe
);
  localparam logic [REG_AW-1:0] STATE_A  = REG_AW'(STATE_ADDR);
  localparam logic [REG_AW-1:0] STATUS_A = REG_AW'(STATUS_ADDR);

  logic hitState, hitStatus, legalCode;

  always_comb begin
    hitState  = regWrEn && (regAddr == STATE_A);
    hitStatus = regWrEn && (regAddr == STATUS_A);
    legalCode = (wrLow == PS_FULL) || (wrLow == PS_LOW);

    strobe.stateVal  = wrLow;
    strobe.stateLoad = hitState && legalCode && (wrLow != curState);
    strobe.rstFire   = strobe.stateLoad && (wrLow == PS_FULL);
    strobe.pmeSet    = wakeEvt && (curState == PS_LOW);
    strobe.pmeClr    = hitStatus && wrLow[0];
  end
endmodule

// File: rtl/devpwr_data_path.sv
module devpwr_data_path
  import devpwr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int REG_AW      = 4,
  parameter int STATE_ADDR  = 0,
  parameter int STATUS_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              mmioReq,
  input  logic              irqRaw,
  output logic [1:0]        curState,
  output logic [DATA_W-1:0] regRdData,
  output logic              mmioDone,
  output logic              mmioAbort,
  output logic              irqOut,
  output logic              pmeOut,
  output logic              fnRstPulse
);
  localparam logic [REG_AW-1:0] STATE_A  = REG_AW'(STATE_ADDR);
  localparam logic [REG_AW-1:0] STATUS_A = REG_AW'(STATUS_ADDR);

  logic pmeSts;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState   <= PS_FULL;
      pmeSts     <= 1'b0;
      fnRstPulse <= 1'b0;
      mmioDone   <= 1'b0;
      mmioAbort  <= 1'b0;
    end else begin
      if (strobe.stateLoad) curState <= strobe.stateVal;
      if (strobe.pmeSet)      pmeSts <= 1'b1;
      else if (strobe.pmeClr) pmeSts <= 1'b0;
      fnRstPulse <= strobe.rstFire;
      mmioDone   <= mmioReq;
      mmioAbort  <= mmioReq && (curState == PS_LOW);
    end
  end

  always_comb begin
    irqOut    = irqRaw && (curState == PS_FULL);
    pmeOut    = pmeSts;
    regRdData = '0;
    if (regAddr == STATE_A)       regRdData[1:0] = curState;
    else if (regAddr == STATUS_A) regRdData[0]   = pmeSts;
  end
endmodule

// File: rtl/devpwr_ctrl.sv
module devpwr_ctrl
  import devpwr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int REG_AW      = 4,
  parameter int STATE_ADDR  = 0,
  parameter int STATUS_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              mmioReq,
  output logic              mmioDone,
  output logic              mmioAbort,
  input  logic              irqRaw,
  output logic              irqOut,
  input  logic              wakeEvt,
  output logic              pmeOut,
  output logic              fnRstPulse
);
  ctrlStrobe_t strobe;
  logic [1:0]  curState;
  logic        unusedHighBits;

  assign unusedHighBits = ^regWrData[DATA_W-1:2];

  devpwr_ctrl_path #(
    .DATA_W(DATA_W), .REG_AW(REG_AW),
    .STATE_ADDR(STATE_ADDR), .STATUS_ADDR(STATUS_ADDR)
  ) u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .wrLow   (regWrData[1:0]),
    .wakeEvt (wakeEvt),
    .curState(curState),
    .strobe  (strobe)
  );

  devpwr_data_path #(
    .DATA_W(DATA_W), .REG_AW(REG_AW),
    .STATE_ADDR(STATE_ADDR), .STATUS_ADDR(STATUS_ADDR)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regAddr   (regAddr),
    .mmioReq   (mmioReq),
    .irqRaw    (irqRaw),
    .curState  (curState),
    .regRdData (regRdData),
    .mmioDone  (mmioDone),
    .mmioAbort (mmioAbort),
    .irqOut    (irqOut),
    .pmeOut    (pmeOut),
    .fnRstPulse(fnRstPulse)
  );
endmodule

// File: rtl/devpwr_chk.sv
module devpwr_chk #(
  parameter int DATA_W     = 32,
  parameter int REG_AW     = 4,
  parameter int STATE_ADDR = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              mmioReq,
  input logic              mmioDone,
  input logic              mmioAbort,
  input logic              irqOut,
  input logic              pmeOut,
  input logic              fnRstPulse,
  input logic [1:0]        curState
);
  localparam logic [REG_AW-1:0] SA = REG_AW'(STATE_ADDR);

  // R2: only the two supported encodings are ever held
  p_legal_state_r2: assert property (@(posedge clk) disable iff (!rstN)
    (curState == 2'b00) || (curState == 2'b11));

  // R3: unsupported codes leave the state alone
  p_drop_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && (regAddr == SA) && (regWrData[1:0] == 2'b01 || regWrData[1:0] == 2'b10)
    |=> curState == $past(curState));

  // R4: leaving low power fires the pulse next cycle
  p_rst_fire_r4: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && (regAddr == SA) && (regWrData[1:0] == 2'b00) && (curState == 2'b11)
    |=> fnRstPulse);

  // R4: pulse is one cycle and only follows a low-to-full move
  p_rst_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    fnRstPulse |=> !fnRstPulse);
  p_rst_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    fnRstPulse |-> (curState == 2'b00) && ($past(curState) == 2'b11));

  // R5: response follows the pre-write state
  p_mmio_abort_r5: assert property (@(posedge clk) disable iff (!rstN)
    mmioReq && (curState == 2'b11) |=> mmioDone && mmioAbort);
  p_mmio_ok_r5: assert property (@(posedge clk) disable iff (!rstN)
    mmioReq && (curState == 2'b00) |=> mmioDone && !mmioAbort);

  // R6: interrupt silenced in low power
  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (curState == 2'b11) |-> !irqOut);

  // R7: event level only rises out of low power
  p_pme_src_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pmeOut) |-> $past(curState) == 2'b11);
endmodule

bind devpwr_ctrl devpwr_chk #(
  .DATA_W(DATA_W), .REG_AW(REG_AW), .STATE_ADDR(STATE_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .mmioReq(mmioReq), .mmioDone(mmioDone),
  .mmioAbort(mmioAbort), .irqOut(irqOut), .pmeOut(pmeOut),
  .fnRstPulse(fnRstPulse), .curState(curState)
);

// File: tb/devpwr_ctrl_tb.sv
module devpwr_ctrl_tb;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int SA = 2;
  localparam int TA = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic mmioReq = 1'b0, mmioDone, mmioAbort;
  logic irqRaw = 1'b0, irqOut;
  logic wakeEvt = 1'b0, pmeOut, fnRstPulse;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  devpwr_ctrl #(.DATA_W(DW), .REG_AW(AW), .STATE_ADDR(SA), .STATUS_ADDR(TA)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mmioReq(mmioReq),
    .mmioDone(mmioDone), .mmioAbort(mmioAbort), .irqRaw(irqRaw),
    .irqOut(irqOut), .wakeEvt(wakeEvt), .pmeOut(pmeOut), .fnRstPulse(fnRstPulse)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // write held for one cycle; returns just after the edge that captures it
  task automatic wr(int a, logic [DW-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = AW'(a); regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rd(int a, output logic [DW-1:0] d);
    @(negedge clk);
    regAddr = AW'(a);
    #1 d = regRdData;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R1 pme", 32'(pmeOut), 0);
    chk("R1 pulse", 32'(fnRstPulse), 0);
    rd(SA, v); chk("R1 state read", 32'(v), 0);
    rd(TA, v); chk("R1 status read", 32'(v), 0);
  endtask

  task automatic t_illegal();
    logic [DW-1:0] v;
    wr(SA, 16'h0001); chk("R3 pulse on 01", 32'(fnRstPulse), 0);
    rd(SA, v); chk("R3 state after 01", 32'(v), 0);
    wr(SA, 16'h0003); chk("R4 no pulse entering low", 32'(fnRstPulse), 0);
    rd(SA, v); chk("R2 state low", 32'(v), 3);
    wr(SA, 16'h0002); chk("R3 pulse on 10", 32'(fnRstPulse), 0);
    rd(SA, v); chk("R3 state after 10", 32'(v), 3);
    wr(SA, 16'hFF03); chk("R4 same-state low write", 32'(fnRstPulse), 0);
    rd(SA, v); chk("R2 high bits ignored", 32'(v), 3);
  endtask

  task automatic t_gating();
    @(negedge clk); irqRaw = 1'b1; #1;
    chk("R6 irq gated in low", 32'(irqOut), 0);
    mmioReq = 1'b1;
    @(posedge clk); #1;
    mmioReq = 1'b0;
    chk("R5 done low", 32'(mmioDone), 1);
    chk("R5 abort low", 32'(mmioAbort), 1);
    @(posedge clk); #1;
    chk("R5 done drops", 32'(mmioDone), 0);
  endtask

  task automatic t_wake();
    logic [DW-1:0] v;
    @(negedge clk); wakeEvt = 1'b1;
    @(posedge clk); #1; wakeEvt = 1'b0;
    chk("R7 pme set", 32'(pmeOut), 1);
    repeat (3) @(posedge clk); #1;
    chk("R7 pme sticky", 32'(pmeOut), 1);
    rd(TA, v); chk("R7 status read", 32'(v), 1);
    wr(TA, 16'h0000); chk("R8 write 0 keeps", 32'(pmeOut), 1);
    wr(TA, 16'h0001); chk("R8 write 1 clears", 32'(pmeOut), 0);
    @(negedge clk);
    wakeEvt = 1'b1; regWrEn = 1'b1; regAddr = AW'(TA); regWrData = 16'h0001;
    @(posedge clk); #1;
    wakeEvt = 1'b0; regWrEn = 1'b0;
    chk("R8 set wins over clear", 32'(pmeOut), 1);
    wr(TA, 16'h0001); chk("R8 cleared again", 32'(pmeOut), 0);
  endtask

  task automatic t_leave();
    logic [DW-1:0] v;
    // state write and access in the same cycle: access judged on low power
    @(negedge clk);
    regWrEn = 1'b1; regAddr = AW'(SA); regWrData = 16'h0000; mmioReq = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0; mmioReq = 1'b0;
    chk("R4 pulse after leaving low", 32'(fnRstPulse), 1);
    chk("R5 same-cycle access aborts", 32'(mmioAbort), 1);
    @(posedge clk); #1;
    chk("R4 pulse one cycle", 32'(fnRstPulse), 0);
    rd(SA, v); chk("R2 state full", 32'(v), 0);
    @(negedge clk); #1;
    chk("R6 irq passes in full", 32'(irqOut), 1);
    irqRaw = 1'b0; #1;
    chk("R6 irq follows raw", 32'(irqOut), 0);
    mmioReq = 1'b1;
    @(posedge clk); #1; mmioReq = 1'b0;
    chk("R5 done full", 32'(mmioDone), 1);
    chk("R5 no abort full", 32'(mmioAbort), 0);
    wr(SA, 16'h0000); chk("R4 same-state full write", 32'(fnRstPulse), 0);
    @(negedge clk); wakeEvt = 1'b1;
    @(posedge clk); #1; wakeEvt = 1'b0;
    chk("R7 wake ignored in full", 32'(pmeOut), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_illegal();
    t_gating();
    t_wake();
    t_leave();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule